// File: doc/BRIEF.md
# Configurable Transform Multiply-Accumulate Cell

This cell is the repeated arithmetic element of a transform fabric. Each cycle it can accept two angle indices, two signed samples and two incoming partial sums. It reads cosine coefficients for the angles from a fixed internal table and forms two products. It then adds the products to the partial sums passed along from a neighbouring cell. A two-bit mode input sets how the products are used. They can be summed into one result, as for cosine, sine and Fourier terms. They can be kept on two separate lanes. In the Hartley setting they come from one sample and two complementary angles. The last mode turns the datapath into an absolute-difference accumulator.

The sine term is produced without a sine table. In Hartley mode the second angle index is replaced by a quarter turn minus the first index, so the cosine table returns sin(θ). In absolute-difference mode the coefficients are forced to plus and minus unity. The sum of the two products is then the scaled difference of the samples, and its magnitude is accumulated.

The cell has three register stages: coefficient fetch, multiply, and combine/accumulate. A valid flag travels through the stages with the data, so the cell takes a new operation every cycle.

Top module: `tcell_mac`

## Requirements
- R1: A synchronous reset (`rst_i` high at a rising edge) clears `out_valid_o`, `acc_re_o` and `acc_im_o` to zero from the next cycle. Operations in flight are discarded.
- R2: `out_valid_o` in cycle c+3 equals `in_valid_i` in cycle c. The results belong to the operands presented in cycle c.
- R3: The coefficient for angle index k (unsigned, six bits, one step = 360°/64) is round-to-nearest of cos(2πk/64)·16384, a signed value with 14 fraction bits. Index 8 gives 11585, index 16 gives 0 and index 32 gives −16384.
- R4: Mode code 0 (pair): `acc_re_o` = `psum_re_i` + x1·C(ang1) + x2·C(ang2), and `acc_im_o` = `psum_im_i`.
- R5: Mode code 1 (Hartley): `acc_re_o` = `psum_re_i` + x1·C(ang1) + x1·C((16 − ang1) mod 64). `x2_i` and `ang2_i` have no effect, and `acc_im_o` = `psum_im_i`.
- R6: Mode code 2 (split): `acc_re_o` = `psum_re_i` + x1·C(ang1) and `acc_im_o` = `psum_im_i` + x2·C(ang2).
- R7: Mode code 3 (absolute difference): `acc_re_o` = `psum_re_i` + |x1 − x2|·16384. Both angle inputs have no effect, and `acc_im_o` = `psum_im_i`.
- R8: All accumulation wraps modulo 2^34 in two's complement.
- R9: Operations presented on consecutive cycles, with mixed modes, each give their own independent result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Operands on this cycle are to be processed |
| mode_i | input | 2 | 0 pair, 1 Hartley, 2 split, 3 absolute difference |
| ang1_i | input | 6 | Angle index for the first coefficient |
| ang2_i | input | 6 | Angle index for the second coefficient |
| x1_i | input | 16 | First signed sample |
| x2_i | input | 16 | Second signed sample |
| psum_re_i | input | 34 | Incoming partial sum, main lane |
| psum_im_i | input | 34 | Incoming partial sum, second lane |
| out_valid_o | output | 1 | Results on this cycle are valid |
| acc_re_o | output | 34 | Accumulated result, main lane |
| acc_im_o | output | 34 | Accumulated result, second lane |

## Verification
The checker assumes that mode and partial sums are sampled only together with the other operands. It therefore relates outputs to input values exactly three edges earlier, and only once three clean cycles have passed since reset. The non-negative gain checked in absolute-difference mode holds because a 16-bit sample difference scaled by 2^14 stays below 2^31, far inside the 34-bit lane. Stimulus drives every operand on the falling edge, with one vector per cycle. Sample extremes are chosen so that wrap-around is reached only through the partial-sum input.

// File: rtl/tcell_pkg.sv
package tcell_pkg;

    localparam int SAMPLE_W  = 16;
    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 14;
    localparam int ANGLE_W   = 6;
    localparam int ACC_W     = 34;

    typedef enum logic [1:0] {
        CELL_PAIR    = 2'b00,
        CELL_HARTLEY = 2'b01,
        CELL_SPLIT   = 2'b10,
        CELL_SAD     = 2'b11
    } cell_mode_e;

    // Rounded cosine sample for one table slot, evaluated at elaboration.
    function automatic int cos_entry(int idx, int steps, int frac);
        real ang;
        real val;
        ang = 2.0 * 3.14159265358979323846 * real'(idx) / real'(steps);
        val = $cos(ang) * real'(64'd1 << frac);
        if (val >= 0.0)
            return $rtoi(val + 0.5);
        else
            return $rtoi(val - 0.5);
    endfunction

endpackage

// File: rtl/tcell_coef_rom.sv
module tcell_coef_rom #(
    parameter int ANGLE_W   = tcell_pkg::ANGLE_W,
    parameter int COEF_W    = tcell_pkg::COEF_W,
    parameter int COEF_FRAC = tcell_pkg::COEF_FRAC
) (
    input  logic [ANGLE_W-1:0]       idx_i,
    output logic signed [COEF_W-1:0] coef_o
);
    localparam int STEPS = 1 << ANGLE_W;

    logic signed [COEF_W-1:0] rom_w [STEPS];

    for (genvar i = 0; i < STEPS; i++) begin : g_slot
        localparam int SLOT_VAL = tcell_pkg::cos_entry(i, STEPS, COEF_FRAC);
        assign rom_w[i] = COEF_W'(SLOT_VAL);
    end

    assign coef_o = rom_w[idx_i];
endmodule

// File: rtl/tcell_mul_stage.sv
module tcell_mul_stage #(
    parameter int SAMPLE_W = tcell_pkg::SAMPLE_W,
    parameter int COEF_W   = tcell_pkg::COEF_W,
    parameter int ACC_W    = tcell_pkg::ACC_W,
    localparam int PROD_W  = SAMPLE_W + COEF_W
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       valid_i,
    input  tcell_pkg::cell_mode_e      mode_i,
    input  logic signed [SAMPLE_W-1:0] samp_i [2],
    input  logic signed [COEF_W-1:0]   coef_i [2],
    input  logic signed [ACC_W-1:0]    psum_re_i,
    input  logic signed [ACC_W-1:0]    psum_im_i,
    output logic                       valid_o,
    output tcell_pkg::cell_mode_e      mode_o,
    output logic signed [PROD_W-1:0]   prod_o [2],
    output logic signed [ACC_W-1:0]    psum_re_o,
    output logic signed [ACC_W-1:0]    psum_im_o
);
    for (genvar g = 0; g < 2; g++) begin : g_mult
        always_ff @(posedge clk_i) begin
            if (rst_i)
                prod_o[g] <= '0;
            else
                prod_o[g] <= samp_i[g] * coef_i[g];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_o   <= 1'b0;
            mode_o    <= tcell_pkg::CELL_PAIR;
            psum_re_o <= '0;
            psum_im_o <= '0;
        end else begin
            valid_o   <= valid_i;
            mode_o    <= mode_i;
            psum_re_o <= psum_re_i;
            psum_im_o <= psum_im_i;
        end
    end
endmodule

// File: rtl/tcell_sum_stage.sv
module tcell_sum_stage #(
    parameter int PROD_W  = tcell_pkg::SAMPLE_W + tcell_pkg::COEF_W,
    parameter int ACC_W   = tcell_pkg::ACC_W,
    localparam int SUM_W  = PROD_W + 1
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     valid_i,
    input  tcell_pkg::cell_mode_e    mode_i,
    input  logic signed [PROD_W-1:0] prod_i [2],
    input  logic signed [ACC_W-1:0]  psum_re_i,
    input  logic signed [ACC_W-1:0]  psum_im_i,
    output logic                     valid_o,
    output logic signed [ACC_W-1:0]  re_o,
    output logic signed [ACC_W-1:0]  im_o
);
    import tcell_pkg::*;

    logic signed [SUM_W-1:0] pair_sum;
    logic signed [SUM_W-1:0] mag_sum;
    logic signed [ACC_W-1:0] re_add;
    logic signed [ACC_W-1:0] im_add;

    assign pair_sum = SUM_W'(prod_i[0]) + SUM_W'(prod_i[1]);
    assign mag_sum  = pair_sum[SUM_W-1] ? -pair_sum : pair_sum;

    always_comb begin
        unique case (mode_i)
            CELL_SPLIT: begin
                re_add = ACC_W'(prod_i[0]);
                im_add = ACC_W'(prod_i[1]);
            end
            CELL_SAD: begin
                re_add = ACC_W'(mag_sum);
                im_add = '0;
            end
            CELL_PAIR, CELL_HARTLEY: begin
                re_add = ACC_W'(pair_sum);
                im_add = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_o <= 1'b0;
            re_o    <= '0;
            im_o    <= '0;
        end else begin
            valid_o <= valid_i;
            re_o    <= psum_re_i + re_add;
            im_o    <= psum_im_i + im_add;
        end
    end
endmodule

// File: rtl/tcell_mac.sv
module tcell_mac #(
    parameter int SAMPLE_W  = tcell_pkg::SAMPLE_W,
    parameter int COEF_W    = tcell_pkg::COEF_W,
    parameter int COEF_FRAC = tcell_pkg::COEF_FRAC,
    parameter int ANGLE_W   = tcell_pkg::ANGLE_W,
    parameter int ACC_W     = tcell_pkg::ACC_W
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       in_valid_i,
    input  logic [1:0]                 mode_i,
    input  logic [ANGLE_W-1:0]         ang1_i,
    input  logic [ANGLE_W-1:0]         ang2_i,
    input  logic signed [SAMPLE_W-1:0] x1_i,
    input  logic signed [SAMPLE_W-1:0] x2_i,
    input  logic signed [ACC_W-1:0]    psum_re_i,
    input  logic signed [ACC_W-1:0]    psum_im_i,
    output logic                       out_valid_o,
    output logic signed [ACC_W-1:0]    acc_re_o,
    output logic signed [ACC_W-1:0]    acc_im_o
);
    import tcell_pkg::*;

    localparam int PROD_W = SAMPLE_W + COEF_W;
    localparam logic [ANGLE_W-1:0]       QUARTER_IDX = ANGLE_W'(1 << (ANGLE_W - 2));
    localparam logic signed [COEF_W-1:0] POS_ONE     = COEF_W'(1 << COEF_FRAC);
    localparam logic signed [COEF_W-1:0] NEG_ONE     = -POS_ONE;

    cell_mode_e mode_e;
    assign mode_e = cell_mode_e'(mode_i);

    // ---- stage 1: coefficient fetch and sample steering ----
    logic [ANGLE_W-1:0]       ang_sel   [2];
    logic signed [COEF_W-1:0] coef_raw  [2];
    logic signed [COEF_W-1:0] coef_next [2];
    logic signed [SAMPLE_W-1:0] samp_next [2];

    assign ang_sel[0] = ang1_i;
    assign ang_sel[1] = (mode_e == CELL_HARTLEY) ? (QUARTER_IDX - ang1_i) : ang2_i;

    for (genvar g = 0; g < 2; g++) begin : g_rom
        tcell_coef_rom #(
            .ANGLE_W  (ANGLE_W),
            .COEF_W   (COEF_W),
            .COEF_FRAC(COEF_FRAC)
        ) rom_i (
            .idx_i (ang_sel[g]),
            .coef_o(coef_raw[g])
        );
    end

    assign coef_next[0] = (mode_e == CELL_SAD) ? POS_ONE : coef_raw[0];
    assign coef_next[1] = (mode_e == CELL_SAD) ? NEG_ONE : coef_raw[1];
    assign samp_next[0] = x1_i;
    assign samp_next[1] = (mode_e == CELL_HARTLEY) ? x1_i : x2_i;

    logic                       s1_valid;
    cell_mode_e                 s1_mode;
    logic signed [COEF_W-1:0]   s1_coef [2];
    logic signed [SAMPLE_W-1:0] s1_samp [2];
    logic signed [ACC_W-1:0]    s1_psum_re;
    logic signed [ACC_W-1:0]    s1_psum_im;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s1_valid   <= 1'b0;
            s1_mode    <= CELL_PAIR;
            s1_coef    <= '{default: '0};
            s1_samp    <= '{default: '0};
            s1_psum_re <= '0;
            s1_psum_im <= '0;
        end else begin
            s1_valid   <= in_valid_i;
            s1_mode    <= mode_e;
            s1_coef    <= coef_next;
            s1_samp    <= samp_next;
            s1_psum_re <= psum_re_i;
            s1_psum_im <= psum_im_i;
        end
    end

    // ---- stage 2: products ----
    logic                     s2_valid;
    cell_mode_e               s2_mode;
    logic signed [PROD_W-1:0] s2_prod [2];
    logic signed [ACC_W-1:0]  s2_psum_re;
    logic signed [ACC_W-1:0]  s2_psum_im;

    tcell_mul_stage #(
        .SAMPLE_W(SAMPLE_W),
        .COEF_W  (COEF_W),
        .ACC_W   (ACC_W)
    ) mul_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .valid_i  (s1_valid),
        .mode_i   (s1_mode),
        .samp_i   (s1_samp),
        .coef_i   (s1_coef),
        .psum_re_i(s1_psum_re),
        .psum_im_i(s1_psum_im),
        .valid_o  (s2_valid),
        .mode_o   (s2_mode),
        .prod_o   (s2_prod),
        .psum_re_o(s2_psum_re),
        .psum_im_o(s2_psum_im)
    );

    // ---- stage 3: combine and accumulate ----
    tcell_sum_stage #(
        .PROD_W(PROD_W),
        .ACC_W (ACC_W)
    ) sum_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .valid_i  (s2_valid),
        .mode_i   (s2_mode),
        .prod_i   (s2_prod),
        .psum_re_i(s2_psum_re),
        .psum_im_i(s2_psum_im),
        .valid_o  (out_valid_o),
        .re_o     (acc_re_o),
        .im_o     (acc_im_o)
    );
endmodule

// File: rtl/tcell_mac_chk.sv
module tcell_mac_chk #(
    parameter int ACC_W = tcell_pkg::ACC_W
) (
    input logic                    clk_i,
    input logic                    rst_i,
    input logic                    in_valid_i,
    input logic [1:0]              mode_i,
    input logic signed [ACC_W-1:0] psum_re_i,
    input logic signed [ACC_W-1:0] psum_im_i,
    input logic                    out_valid_o,
    input logic signed [ACC_W-1:0] acc_re_o,
    input logic signed [ACC_W-1:0] acc_im_o
);
    logic [1:0]              since_rst;
    logic signed [ACC_W-1:0] re_hist [3];
    logic signed [ACC_W-1:0] sad_gain;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            since_rst <= 2'd0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    always_ff @(posedge clk_i) begin
        re_hist[0] <= psum_re_i;
        re_hist[1] <= re_hist[0];
        re_hist[2] <= re_hist[1];
    end

    assign sad_gain = acc_re_o - re_hist[2];

    // R1
    reset_clear_chk: assert property (@(posedge clk_i)
        rst_i |=> (!out_valid_o && acc_re_o == '0 && acc_im_o == '0));

    // R2
    valid_latency_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (since_rst == 2'd3) |-> (out_valid_o == $past(in_valid_i, 3)));

    // R4
    im_passthru_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (since_rst == 2'd3 && out_valid_o && $past(mode_i, 3) != 2'b10)
        |-> (acc_im_o == $past(psum_im_i, 3)));

    // R7
    sad_gain_sign_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (since_rst == 2'd3 && out_valid_o && $past(mode_i, 3) == 2'b11)
        |-> !sad_gain[ACC_W-1]);
endmodule

bind tcell_mac tcell_mac_chk #(.ACC_W(ACC_W)) chk_i (.*);

// File: tb/tcell_mac_tb_top.sv
module tcell_mac_tb_top;

    typedef logic signed [33:0] acc_t;

    typedef struct packed {
        logic              vld;
        logic [1:0]        mode;
        logic [5:0]        a1;
        logic [5:0]        a2;
        logic signed [15:0] s1;
        logic signed [15:0] s2;
        logic signed [33:0] pr;
        logic signed [33:0] pi;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 6'd0,  6'd32, 16'sd100,    16'sd50,    34'sd0,        34'sd0},      // R4
        '{1'b1, 2'd0, 6'd8,  6'd24, -16'sd300,   16'sd7000,  34'sd1000,     -34'sd5},     // R4
        '{1'b1, 2'd1, 6'd5,  6'd40, 16'sd1234,   -16'sd999,  34'sd77,       34'sd12},     // R5
        '{1'b1, 2'd1, 6'd0,  6'd9,  -16'sd2000,  16'sd31000, -34'sd40000,   34'sd3},      // R5
        '{1'b0, 2'd0, 6'd1,  6'd2,  16'sd5,      16'sd6,     34'sd9,        34'sd9},      // R2 gap
        '{1'b1, 2'd1, 6'd60, 6'd1,  16'sd32767,  16'sd0,     34'sd0,        34'sd0},      // R5
        '{1'b1, 2'd2, 6'd3,  6'd50, 16'sd32767,  -16'sd32768, 34'sd11,      -34'sd22},    // R6
        '{1'b1, 2'd2, 6'd40, 6'd16, -16'sd1500,  16'sd2500,  34'sd0,        34'sd100},    // R6
        '{1'b1, 2'd3, 6'd7,  6'd33, 16'sd10,     16'sd300,   34'sd5,        34'sd44},     // R7
        '{1'b1, 2'd3, 6'd0,  6'd0,  -16'sd32768, 16'sd32767, 34'sd0,        -34'sd1},     // R7
        '{1'b1, 2'd3, 6'd21, 6'd63, 16'sd1234,   16'sd1234,  -34'sd8,       34'sd0},      // R7
        '{1'b1, 2'd0, 6'd32, 6'd32, -16'sd32768, -16'sd32768, 34'sh1FFFFFFFF, 34'sd0},    // R8
        '{1'b1, 2'd2, 6'd0,  6'd32, 16'sd1,      16'sd1,     -34'sh200000000, 34'sh1FFFFFFFF}, // R8
        '{1'b1, 2'd0, 6'd63, 6'd1,  16'sd4321,   -16'sd4321, -34'sd123456,  34'sd0}       // R4
    };

    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic       in_valid_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic [5:0] ang1_i = '0;
    logic [5:0] ang2_i = '0;
    logic signed [15:0] x1_i = '0;
    logic signed [15:0] x2_i = '0;
    logic signed [33:0] psum_re_i = '0;
    logic signed [33:0] psum_im_i = '0;
    logic       out_valid_o;
    logic signed [33:0] acc_re_o;
    logic signed [33:0] acc_im_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    vec_t hist [3];
    bit   live [3];

    always #4 clk_i = ~clk_i;

    tcell_mac dut_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .in_valid_i (in_valid_i),
        .mode_i     (mode_i),
        .ang1_i     (ang1_i),
        .ang2_i     (ang2_i),
        .x1_i       (x1_i),
        .x2_i       (x2_i),
        .psum_re_i  (psum_re_i),
        .psum_im_i  (psum_im_i),
        .out_valid_o(out_valid_o),
        .acc_re_o   (acc_re_o),
        .acc_im_o   (acc_im_o)
    );

    function automatic longint coef(logic [5:0] k);
        real v;
        v = $cos(2.0 * 3.14159265358979323846 * real'(k) / 64.0) * 16384.0;
        if (v >= 0.0) return longint'($rtoi(v + 0.5));
        return longint'($rtoi(v - 0.5));
    endfunction

    function automatic void model(vec_t v, output longint re, output longint im);
        longint r;
        longint i;
        longint d;
        logic [5:0] kh;
        r = longint'(v.pr);
        i = longint'(v.pi);
        case (v.mode)
            2'd0: r += longint'(v.s1) * coef(v.a1) + longint'(v.s2) * coef(v.a2);
            2'd1: begin
                kh = 6'd16 - v.a1;
                r += longint'(v.s1) * (coef(v.a1) + coef(kh));
            end
            2'd2: begin
                r += longint'(v.s1) * coef(v.a1);
                i += longint'(v.s2) * coef(v.a2);
            end
            default: begin
                d = longint'(v.s1) - longint'(v.s2);
                if (d < 0) d = -d;
                r += d * 16384;
            end
        endcase
        re = longint'(acc_t'(r));
        im = longint'(acc_t'(i));
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(vec_t v);
        in_valid_i = v.vld;
        mode_i     = v.mode;
        ang1_i     = v.a1;
        ang2_i     = v.a2;
        x1_i       = v.s1;
        x2_i       = v.s2;
        psum_re_i  = v.pr;
        psum_im_i  = v.pi;
    endtask

    // One falling edge: check the entry driven three steps ago, then drive v.
    task automatic step(vec_t v, string req);
        longint er;
        longint ei;
        @(negedge clk_i);
        if (live[2]) begin
            check({req, "/R2 valid"}, longint'(out_valid_o), longint'(hist[2].vld));
            if (hist[2].vld) begin
                model(hist[2], er, ei);
                check({req, " re"}, longint'(acc_re_o), er);
                check({req, " im"}, longint'(acc_im_o), ei);
            end
        end
        hist[2] = hist[1]; live[2] = live[1];
        hist[1] = hist[0]; live[1] = live[0];
        hist[0] = v;       live[0] = 1'b1;
        drive(v);
    endtask

    task automatic flush(string req);
        vec_t idle;
        idle = '0;
        for (int n = 0; n < 3; n++) step(idle, req);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        vec_t v;
        live = '{default: 1'b0};
        hist = '{default: '0};

        // R1: state while held in reset
        repeat (3) @(negedge clk_i);
        check("R1 valid", longint'(out_valid_o), 0);
        check("R1 re", longint'(acc_re_o), 0);
        check("R1 im", longint'(acc_im_o), 0);
        rst_i = 1'b0;

        // R9: table vectors back to back, all modes mixed
        for (int i = 0; i < NV; i++) step(VECS[i], "R9 table");
        flush("R9 flush");

        // R3: every table slot through pair mode with unit sample
        for (int k = 0; k < 64; k++) begin
            v = '{1'b1, 2'd0, 6'(k), 6'd0, 16'sd1, 16'sd0, 34'sd0, 34'sd0};
            step(v, "R3 coef");
        end
        flush("R3 flush");

        // R5: Hartley ignores x2 and ang2 (same x1/ang1, different others)
        v = '{1'b1, 2'd1, 6'd12, 6'd3, 16'sd900, 16'sd17, 34'sd0, 34'sd0};
        step(v, "R5 ign a");
        v = '{1'b1, 2'd1, 6'd12, 6'd50, 16'sd900, -16'sd32000, 34'sd0, 34'sd0};
        step(v, "R5 ign b");
        // R7: absolute difference ignores angles
        v = '{1'b1, 2'd3, 6'd1, 6'd2, 16'sd700, -16'sd700, 34'sd0, 34'sd0};
        step(v, "R7 ign a");
        v = '{1'b1, 2'd3, 6'd45, 6'd31, 16'sd700, -16'sd700, 34'sd0, 34'sd0};
        step(v, "R7 ign b");
        flush("R7 flush");

        // R1: reset while operations are in flight
        v = '{1'b1, 2'd0, 6'd0, 6'd0, 16'sd5, 16'sd5, 34'sd1, 34'sd1};
        @(negedge clk_i);
        drive(v);
        @(negedge clk_i);
        v = '0;
        drive(v);
        rst_i = 1'b1;
        @(negedge clk_i);
        rst_i = 1'b0;
        check("R1 midreset valid", longint'(out_valid_o), 0);
        check("R1 midreset re", longint'(acc_re_o), 0);
        repeat (3) begin
            @(negedge clk_i);
            check("R1 discard", longint'(out_valid_o), 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule